// File: doc/BRIEF.md
# Victim Line Buffer Controller

This block is a small fully associative store that sits next to a direct-mapped first-level data cache. When the primary cache refills a line, the line it pushes out is handed to this block and kept here. When the primary cache misses, the processor's line address is presented to the block in the same cycle as the request to the next memory level. If the line is held here, the block cancels that outgoing request and returns the whole line to the processor a fixed number of cycles later. Primary-cache hits are flagged on the lookup port and leave the block untouched.

The default build holds four 32-byte lines. Replacement is least-recently-used. Both a lookup hit and a stored eviction count as a use.

Top module: `vbuf_ctrl`

## Requirements
- R1: After reset every entry is invalid. No lookup hits until a line has been written, and `mem_abort` and `rsp_valid` are low.
- R2: A lookup presented with `acc_l1_hit`=1 is ignored. It causes no abort and no response, and it does not change the replacement order.
- R3: A lookup with `acc_valid`=1 and `acc_l1_hit`=0 whose line address matches a valid entry raises `mem_abort` in the cycle after the lookup. `mem_abort` is high only in cycles that follow such a hit.
- R4: For a hitting lookup, `rsp_valid` is high and `rsp_data` carries the 256-bit line exactly HIT_LAT (default 2) cycles after the lookup cycle. `rsp_valid` is low in all other cycles.
- R5: A lookup whose address matches no valid entry and no same-cycle eviction produces neither an abort nor a response.
- R6: An eviction (`evc_valid`=1) stores its line address and data, and later lookups of that address hit with that data. Up to ENTRIES (default 4) lines are held at once.
- R7: An eviction whose address is already held overwrites that entry's data and does not create a second copy. Otherwise it fills an invalid entry if one exists, and only when all entries are valid does it replace the least recently used one.
- R8: A lookup hit and an eviction each make the touched entry the most recently used. The entry to replace is taken from the order as it stood at the start of the cycle.
- R9: When a lookup and an eviction carry the same address in one cycle, the lookup hits and returns the eviction's data.
- R10: When a lookup hits one address while an eviction of a different address arrives in the same cycle, both take effect. The response carries the data held before that cycle, even if the hit entry is the one being replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Lookup request from the primary cache |
| acc_l1_hit | input | 1 | Lookup hit in the primary cache; the block ignores it |
| acc_line | input | LA_W (27) | Line address of the lookup |
| evc_valid | input | 1 | Line displaced from the primary cache is offered |
| evc_line | input | LA_W (27) | Line address of the displaced line |
| evc_data | input | LINE_W (256) | Contents of the displaced line |
| mem_abort | output | 1 | Cancel the outstanding lower-level request |
| rsp_valid | output | 1 | Line returned to the processor |
| rsp_data | output | LINE_W (256) | Returned line contents |

## Verification
A lookup and an eviction can arrive in the same cycle, and the hard part of this block is resolving them together. The bench drives that collision three ways: with the same address on both ports, with a hit on the entry that is about to be replaced, and with a hit on some other entry. A behavioural ordered-list model predicts each result. It decides hit and data from the state before the cycle, applies the hit touch, and then inserts the eviction at the most-recent end, removing the victim that was oldest at the start of the cycle. Every cycle the abort, the response valid and the response data are compared against that model, and later probes reveal which line was dropped.

// File: rtl/vbuf_pkg.sv
package vbuf_pkg;

   // How an incoming eviction chose its slot
   typedef enum logic [1:0] {
      FILL_NONE   = 2'd0,
      FILL_SAME   = 2'd1,
      FILL_FREE   = 2'd2,
      FILL_OLDEST = 2'd3
   } fill_kind_e;

endpackage

// File: rtl/vbuf_store.sv
module vbuf_store #(
   parameter int ENTRIES = 4,
   parameter int TAG_W   = 27,
   parameter int DATA_W  = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ENTRIES-1:0] wr_sel,
   input  logic [TAG_W-1:0]   wr_tag,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [TAG_W-1:0]   look_tag,
   input  logic [TAG_W-1:0]   probe_tag,
   output logic [ENTRIES-1:0] valid_o,
   output logic [ENTRIES-1:0] look_hit_o,
   output logic [ENTRIES-1:0] probe_hit_o,
   output logic [DATA_W-1:0]  look_data_o
);

   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q  [ENTRIES];
   logic [DATA_W-1:0]  data_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q <= valid_q | wr_sel;
      end
   end

   always_ff @(posedge clk) begin
      for (int e = 0; e < ENTRIES; e++) begin
         if (wr_en && wr_sel[e]) begin
            tag_q[e]  <= wr_tag;
            data_q[e] <= wr_data;
         end
      end
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign look_hit_o[e]  = valid_q[e] && (tag_q[e] == look_tag);
      assign probe_hit_o[e] = valid_q[e] && (tag_q[e] == probe_tag);
   end

   always_comb begin
      look_data_o = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (look_hit_o[e]) look_data_o = look_data_o | data_q[e];
      end
   end

   assign valid_o = valid_q;

   AST_NO_DUP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(look_hit_o)) else $error("duplicate line held"); // R7

   AST_VALID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      ((valid_q & $past(valid_q)) == $past(valid_q))) else $error("entry lost"); // R6

endmodule

// File: rtl/vbuf_lru.sv
module vbuf_lru #(
   parameter int ENTRIES = 4,
   parameter int IDX_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_a_en,
   input  logic [IDX_W-1:0] touch_a_idx,
   input  logic             touch_b_en,
   input  logic [IDX_W-1:0] touch_b_idx,
   output logic [IDX_W-1:0] oldest_idx
);

   // rank 0 = most recent, ENTRIES-1 = least recent
   logic [IDX_W-1:0] rank_q   [ENTRIES];
   logic [IDX_W-1:0] rank_mid [ENTRIES];
   logic [IDX_W-1:0] rank_nxt [ENTRIES];

   always_comb begin
      rank_mid = rank_q;
      if (touch_a_en) begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (rank_q[e] < rank_q[touch_a_idx]) rank_mid[e] = rank_q[e] + 1'b1;
         end
         rank_mid[touch_a_idx] = '0;
      end
      rank_nxt = rank_mid;
      if (touch_b_en) begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (rank_mid[e] < rank_mid[touch_b_idx]) rank_nxt[e] = rank_mid[e] + 1'b1;
         end
         rank_nxt[touch_b_idx] = '0;
      end
   end

   always_comb begin
      oldest_idx = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (rank_q[e] == IDX_W'(ENTRIES - 1)) oldest_idx = IDX_W'(e);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) rank_q[e] <= IDX_W'(e);
      end else begin
         rank_q <= rank_nxt;
      end
   end

   for (genvar r = 0; r < ENTRIES; r++) begin : g_perm
      logic [ENTRIES-1:0] holders;
      always_comb begin
         for (int e = 0; e < ENTRIES; e++) holders[e] = (rank_q[e] == IDX_W'(r));
      end
      AST_LRU_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot(holders)) else $error("rank %0d not unique", r); // R8
   end

   AST_LRU_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (!touch_a_en && !touch_b_en) |=> $stable(oldest_idx)) else $error("order moved"); // R8

endmodule

// File: rtl/vbuf_rsp.sv
module vbuf_rsp #(
   parameter int DATA_W  = 256,
   parameter int HIT_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_en,
   input  logic [DATA_W-1:0] hit_data,
   output logic              abort_o,
   output logic              rsp_valid_o,
   output logic [DATA_W-1:0] rsp_data_o
);

   logic [HIT_LAT-1:0] v_q;
   logic [DATA_W-1:0]  d_q [HIT_LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) abort_o <= 1'b0;
      else        abort_o <= hit_en;
   end

   if (HIT_LAT == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) v_q <= '0;
         else        v_q <= hit_en;
      end
      always_ff @(posedge clk) begin
         if (hit_en) d_q[0] <= hit_data;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) v_q <= '0;
         else        v_q <= {v_q[HIT_LAT-2:0], hit_en};
      end
      always_ff @(posedge clk) begin
         if (hit_en) d_q[0] <= hit_data;
         for (int s = 1; s < HIT_LAT; s++) begin
            if (v_q[s-1]) d_q[s] <= d_q[s-1];
         end
      end
      AST_RSP_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid_o |-> $past(abort_o, HIT_LAT - 1)) else $error("response without abort"); // R4
   end

   assign rsp_valid_o = v_q[HIT_LAT-1];
   assign rsp_data_o  = d_q[HIT_LAT-1];

endmodule

// File: rtl/vbuf_ctrl.sv
module vbuf_ctrl
   import vbuf_pkg::*;
#(
   parameter int ENTRIES    = 4,
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int HIT_LAT    = 2,
   localparam int LA_W      = ADDR_W - $clog2(LINE_BYTES),
   localparam int LINE_W    = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_l1_hit,
   input  logic [LA_W-1:0]   acc_line,
   input  logic              evc_valid,
   input  logic [LA_W-1:0]   evc_line,
   input  logic [LINE_W-1:0] evc_data,
   output logic              mem_abort,
   output logic              rsp_valid,
   output logic [LINE_W-1:0] rsp_data
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2)                              begin : g_chk_ent  $error("ENTRIES must be at least 2");  end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0)     begin : g_chk_line $error("LINE_BYTES must be a power of two"); end
   if (HIT_LAT < 1 || HIT_LAT > 4)               begin : g_chk_lat  $error("HIT_LAT must be 1 to 4");      end
   if (LA_W < 1)                                 begin : g_chk_addr $error("ADDR_W too small");            end

   logic [ENTRIES-1:0] valid_vec, look_hit, probe_hit, fill_sel;
   logic [LINE_W-1:0]  look_data, hit_data;
   logic [IDX_W-1:0]   oldest_idx, free_idx, same_idx, look_idx, fill_idx;
   logic               lookup_en, bypass, old_hit, hit_any;
   fill_kind_e         fill_kind;

   assign lookup_en = acc_valid && !acc_l1_hit;

   vbuf_store #(.ENTRIES(ENTRIES), .TAG_W(LA_W), .DATA_W(LINE_W)) u_store (
      .clk, .rst_n,
      .wr_en      (evc_valid),
      .wr_sel     (fill_sel),
      .wr_tag     (evc_line),
      .wr_data    (evc_data),
      .look_tag   (acc_line),
      .probe_tag  (evc_line),
      .valid_o    (valid_vec),
      .look_hit_o (look_hit),
      .probe_hit_o(probe_hit),
      .look_data_o(look_data)
   );

   // index encoders: lowest free slot, matching slots
   always_comb begin
      free_idx = '0;
      same_idx = '0;
      look_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (!valid_vec[e]) free_idx = IDX_W'(e);
      end
      for (int e = 0; e < ENTRIES; e++) begin
         if (probe_hit[e]) same_idx = same_idx | IDX_W'(e);
         if (look_hit[e])  look_idx = look_idx | IDX_W'(e);
      end
   end

   // slot choice for an eviction, from start-of-cycle state
   always_comb begin
      if (!evc_valid)          fill_kind = FILL_NONE;
      else if (|probe_hit)     fill_kind = FILL_SAME;
      else if (!(&valid_vec))  fill_kind = FILL_FREE;
      else                     fill_kind = FILL_OLDEST;
      case (fill_kind)
         FILL_SAME: fill_idx = same_idx;
         FILL_FREE: fill_idx = free_idx;
         default:   fill_idx = oldest_idx;
      endcase
      fill_sel = (fill_kind == FILL_NONE) ? '0 : (ENTRIES'(1) << fill_idx);
   end

   assign bypass   = lookup_en && evc_valid && (evc_line == acc_line);
   assign old_hit  = lookup_en && (|look_hit);
   assign hit_any  = bypass || old_hit;
   assign hit_data = bypass ? evc_data : look_data;

   vbuf_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
      .clk, .rst_n,
      .touch_a_en (old_hit),
      .touch_a_idx(look_idx),
      .touch_b_en (evc_valid),
      .touch_b_idx(fill_idx),
      .oldest_idx (oldest_idx)
   );

   vbuf_rsp #(.DATA_W(LINE_W), .HIT_LAT(HIT_LAT)) u_rsp (
      .clk, .rst_n,
      .hit_en     (hit_any),
      .hit_data   (hit_data),
      .abort_o    (mem_abort),
      .rsp_valid_o(rsp_valid),
      .rsp_data_o (rsp_data)
   );

   AST_ABORT_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_abort |-> $past(acc_valid && !acc_l1_hit)) else $error("abort without lookup"); // R2

   AST_FILL_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (evc_valid && !(|probe_hit) && !(&valid_vec)) |=>
      ($countones(valid_vec) == $past($countones(valid_vec)) + 1)) else $error("free slot skipped"); // R7

   AST_SAME_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
      (evc_valid && (|probe_hit)) |=> $stable(valid_vec)) else $error("duplicate fill"); // R7

endmodule

// File: tb/vbuf_ctrl_tb_top.sv
module vbuf_ctrl_tb_top;

   localparam int NE   = 4;
   localparam int LA_W = 27;
   localparam int LW   = 256;
   localparam int LAT  = 2;

   typedef struct {
      logic [LA_W-1:0] a;
      logic [LW-1:0]   d;
   } ent_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            acc_valid = 1'b0, acc_l1_hit = 1'b0, evc_valid = 1'b0;
   logic [LA_W-1:0] acc_line = '0, evc_line = '0;
   logic [LW-1:0]   evc_data = '0;
   logic            mem_abort, rsp_valid;
   logic [LW-1:0]   rsp_data;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   ent_t     model_q[$];
   bit       exp_ab = 1'b0;
   string    ab_tag = "R1";
   bit       r_v   [LAT+1];
   logic [LW-1:0] r_d [LAT+1];
   string    r_tag [LAT+1];

   always #5 clk = ~clk;

   vbuf_ctrl dut_i (
      .clk, .rst_n,
      .acc_valid, .acc_l1_hit, .acc_line,
      .evc_valid, .evc_line, .evc_data,
      .mem_abort, .rsp_valid, .rsp_data
   );

   function automatic logic [LW-1:0] mkd(input int s);
      logic [LW-1:0] d;
      for (int w = 0; w < LW / 32; w++) d[w*32 +: 32] = 32'(s) * 32'h9E3779B1 + 32'(w) * 32'h01234567;
      return d;
   endfunction

   function automatic int find(input logic [LA_W-1:0] a);
      for (int i = 0; i < model_q.size(); i++) if (model_q[i].a == a) return i;
      return -1;
   endfunction

   task automatic chk(input string tag, input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      chk(ab_tag, "mem_abort", LW'(mem_abort), LW'(exp_ab));
      chk(r_tag[1], "rsp_valid", LW'(rsp_valid), LW'(r_v[1]));
      if (r_v[1]) chk(r_tag[1], "rsp_data", rsp_data, r_d[1]);
      for (int i = 1; i < LAT; i++) begin
         r_v[i] = r_v[i+1]; r_d[i] = r_d[i+1]; r_tag[i] = r_tag[i+1];
      end
   endtask

   // one cycle: check outputs, drive inputs, advance reference model
   task automatic cyc(input string tag, input bit av, input bit l1, input int la,
                      input bit ev, input int ea, input int ds);
      bit            hit;
      logic [LW-1:0] hd;
      int            idx;
      bit            have_vict;
      logic [LA_W-1:0] vict;
      ent_t          e;
      @(negedge clk);
      compare();
      acc_valid = av; acc_l1_hit = l1; acc_line = LA_W'(la);
      evc_valid = ev; evc_line = LA_W'(ea); evc_data = mkd(ds);
      hit = 1'b0; hd = '0; idx = -1;
      if (av && !l1) begin
         if (ev && LA_W'(ea) == LA_W'(la)) begin
            hit = 1'b1; hd = mkd(ds);
         end else begin
            idx = find(LA_W'(la));
            if (idx >= 0) begin hit = 1'b1; hd = model_q[idx].d; end
         end
      end
      have_vict = 1'b0; vict = '0;
      if (ev && find(LA_W'(ea)) < 0 && model_q.size() == NE) begin
         have_vict = 1'b1; vict = model_q[NE-1].a;
      end
      if (idx >= 0) begin
         e = model_q[idx]; model_q.delete(idx); model_q.push_front(e);
      end
      if (ev) begin
         if (find(LA_W'(ea)) >= 0) model_q.delete(find(LA_W'(ea)));
         else if (have_vict) model_q.delete(find(vict));
         e.a = LA_W'(ea); e.d = mkd(ds);
         model_q.push_front(e);
      end
      exp_ab = hit; ab_tag = tag;
      r_v[LAT] = hit; r_d[LAT] = hd; r_tag[LAT] = tag;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc("R5", 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      for (int i = 0; i <= LAT; i++) begin r_v[i] = 1'b0; r_d[i] = '0; r_tag[i] = "R1"; end
      repeat (3) @(negedge clk);
      // R1: outputs quiet while held in reset
      chk("R1", "abort in reset", LW'(mem_abort), '0);
      chk("R1", "rsp_valid in reset", LW'(rsp_valid), '0);
      rst_n = 1'b1;
      // R1: empty after reset
      cyc("R1", 1, 0, 'h10, 0, 0, 0);
      cyc("R1", 1, 0, 'h0, 0, 0, 0);
      idle(2);
      // R6: store three lines, then hit one
      cyc("R6", 0, 0, 0, 1, 'h10, 100);
      cyc("R6", 0, 0, 0, 1, 'h11, 101);
      cyc("R6", 0, 0, 0, 1, 'h12, 102);
      cyc("R6", 1, 0, 'h11, 0, 0, 0);
      // R3 R4: back-to-back hits
      cyc("R3", 1, 0, 'h10, 0, 0, 0);
      cyc("R4", 1, 0, 'h12, 0, 0, 0);
      // R2: primary-cache hit ignored
      cyc("R2", 1, 1, 'h10, 0, 0, 0);
      idle(1);
      // R5: miss
      cyc("R5", 1, 0, 'h55, 0, 0, 0);
      // R7: last free slot, then LRU replacement after touching 0x11
      cyc("R7", 0, 0, 0, 1, 'h13, 103);
      cyc("R8", 1, 0, 'h11, 0, 0, 0);
      cyc("R2", 1, 1, 'h10, 0, 0, 0);
      cyc("R7", 0, 0, 0, 1, 'h14, 104);
      for (int a = 'h10; a <= 'h14; a++) cyc("R8", 1, 0, a, 0, 0, 0);
      // R7: overwrite of a held line
      cyc("R7", 0, 0, 0, 1, 'h12, 202);
      cyc("R7", 1, 0, 'h12, 0, 0, 0);
      for (int a = 'h10; a <= 'h14; a++) cyc("R7", 1, 0, a, 0, 0, 0);
      // R9: same address on both ports
      cyc("R9", 1, 0, 'h20, 1, 'h20, 300);
      cyc("R9", 1, 0, 'h20, 0, 0, 0);
      // R10: hit on the oldest entry while a new line replaces it
      cyc("R10", 1, 0, 'h14, 1, 'h21, 301);
      cyc("R10", 1, 0, 'h13, 1, 'h22, 302);
      for (int a = 'h10; a <= 'h22; a++) cyc("R10", 1, 0, a, 0, 0, 0);
      idle(3);
      // mixed traffic over a small address set
      begin
         logic [31:0] x = 32'h1234_5678;
         for (int i = 0; i < 600; i++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            cyc("R8", x[0] | x[1], x[2] & x[3] & x[4], int'(x[10:8]),
                x[5] & ~x[6] | x[7] & x[11], int'(x[14:12]), i + 1000);
         end
      end
      idle(LAT + 2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule